// File: doc/BRIEF.md
# Module Descriptor Integrity Checker

This block checks whether a memory-module descriptor image is intact. The image sits in a 256-byte store that the block reads one byte per cycle through a read port with one cycle of latency. A start pulse launches a check. The block first fetches the memory-type code and the first image byte. From these it chooses the check method and the range of bytes it covers. It then streams that range through an accumulator, fetches the stored check value and compares the two.

Older module types carry a plain 8-bit additive checksum. The newer type carries a 16-bit CRC. Its covered range is set by a flag inside the image, so a serial-number area can be left out of the check. When the check ends, the block emits a one-cycle done pulse. The pass flag, the error flag and the computed value then hold until the next accepted start. A system bring-up sequencer uses the block to reject a corrupted descriptor before it programs a memory controller from it.

Top module: `desc_integrity_chk`

## Requirements
- R1: After reset, done_o, pass_o and err_o are 0 and rd_valid_o is 0.
- R2: When byte 2 holds type code 4, 7 or 8, the check adds bytes 0 to 62 modulo 256, with no complement. pass_o is 1 when the sum equals byte 63.
- R3: For the types in R2, a sum that differs from byte 63 gives pass_o = 0, and calc_o holds the computed sum in bits 7:0 with zeros above.
- R4: When byte 2 holds type code 11 and bit 7 of byte 0 is clear, the check runs a CRC-16 over bytes 0 to 125. The CRC uses polynomial 0x1021, a start value of 0, MSB-first bit order and no final XOR. It is compared with byte 126 as the low half and byte 127 as the high half, and calc_o shows the computed CRC.
- R5: For type code 11 with bit 7 of byte 0 set, the CRC covers bytes 0 to 116 only, so a change to bytes 117 to 125 does not affect the result.
- R6: Any other type code ends the check after two reads with done_o pulsed, pass_o = 0 and err_o = 1. A later valid check clears err_o.
- R7: A start pulse that arrives while a check is running is ignored. The running check finishes with a single done pulse and its normal read count.
- R8: done_o is high for exactly one cycle per check. pass_o and err_o hold their values until the next accepted start.
- R9: Reads go in this order: address 2, then address 0, then the covered range in ascending order, then the stored check bytes. That makes 66 reads for the checksum types, 130 reads for the full CRC range and 121 reads for the short range. The read address never exceeds 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse to begin a check; ignored while busy |
| rd_valid_o | output | 1 | Read request to the descriptor store |
| rd_addr_o | output | 8 | Byte address of the read request |
| rd_data_i | input | 8 | Read data, valid the cycle after the request |
| done_o | output | 1 | One-cycle pulse when a check ends |
| pass_o | output | 1 | Image intact; held until the next start |
| err_o | output | 1 | Unrecognised type code; held until the next start |
| calc_o | output | 16 | Computed checksum (zero-extended) or CRC |

## Verification
A wrong range bound or a wrong method choice shows in two ways. The read count changes, and a pass flips after a single byte is corrupted inside or outside the range, so it is seen at the one done pulse of the run. A broken accumulator or CRC step shows as a wrong calc_o on every intact image. A broken busy guard shows as a second done pulse or as extra reads within a few cycles of the stray start.

// File: rtl/desc_chk_pkg.sv
package desc_chk_pkg;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CW = 16;

    localparam logic [DW-1:0] TYPE_SDR  = 8'd4;
    localparam logic [DW-1:0] TYPE_DDR  = 8'd7;
    localparam logic [DW-1:0] TYPE_DDR2 = 8'd8;
    localparam logic [DW-1:0] TYPE_DDR3 = 8'd11;

    localparam logic [AW-1:0] ADDR_TYPE     = 8'd2;
    localparam logic [AW-1:0] ADDR_CFG      = 8'd0;
    localparam logic [AW-1:0] SUM_LAST      = 8'd62;
    localparam logic [AW-1:0] SUM_STORED    = 8'd63;
    localparam logic [AW-1:0] CRC_LAST_LONG = 8'd125;
    localparam logic [AW-1:0] CRC_LAST_SHRT = 8'd116;
    localparam logic [AW-1:0] CRC_STORED_LO = 8'd126;
    localparam logic [AW-1:0] CRC_STORED_HI = 8'd127;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TYPE,
        ST_CFG,
        ST_SEL,
        ST_STREAM,
        ST_CHK1,
        ST_CHK2,
        ST_CHK3
    } chk_state_e;

    typedef struct packed {
        chk_state_e      state;
        logic [AW-1:0]   idx;
        logic [AW-1:0]   last;
        logic [AW-1:0]   stored;
        logic            is_crc;
        logic [DW-1:0]   mtype;
        logic [DW-1:0]   lo;
        logic            feed;
        logic            done;
        logic            pass;
        logic            err;
    } chk_regs_t;

endpackage

// File: rtl/desc_sum_acc.sv
module desc_sum_acc #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] sum_o
);
    logic [DW-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr_i)      sum_d = '0;
        else if (en_i)  sum_d = sum_q + din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum_o = sum_q;
endmodule

// File: rtl/desc_crc16.sv
module desc_crc16 #(
    parameter int          DW   = 8,
    parameter int          CW   = 16,
    parameter logic [CW-1:0] POLY = 16'h1021,
    parameter logic [CW-1:0] INIT = 16'h0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [DW-1:0] din_i,
    output logic [CW-1:0] crc_o
);
    logic [CW-1:0] crc_d, crc_q, step;
    logic          fb;

    // MSB-first bitwise update across one input byte
    always_comb begin
        step = crc_q;
        fb   = 1'b0;
        for (int i = DW-1; i >= 0; i--) begin
            fb   = step[CW-1] ^ din_i[i];
            step = {step[CW-2:0], 1'b0};
            if (fb) step = step ^ POLY;
        end
    end

    always_comb begin
        crc_d = crc_q;
        if (clr_i)     crc_d = INIT;
        else if (en_i) crc_d = step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/desc_integrity_chk.sv
module desc_integrity_chk
    import desc_chk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          rd_valid_o,
    output logic [7:0]    rd_addr_o,
    input  logic [7:0]    rd_data_i,
    output logic          done_o,
    output logic          pass_o,
    output logic          err_o,
    output logic [15:0]   calc_o
);
    chk_regs_t     r_d, r_q;
    logic          accept;
    logic [DW-1:0] sum_val;
    logic [CW-1:0] crc_val;

    assign accept = (r_q.state == ST_IDLE) && start_i;

    desc_sum_acc #(.DW(DW)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (accept),
        .en_i  (r_q.feed && !r_q.is_crc),
        .din_i (rd_data_i),
        .sum_o (sum_val)
    );

    desc_crc16 #(.DW(DW), .CW(CW)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (accept),
        .en_i  (r_q.feed && r_q.is_crc),
        .din_i (rd_data_i),
        .crc_o (crc_val)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.feed   = 1'b0;
        rd_valid_o = 1'b0;
        rd_addr_o  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_TYPE;
                    r_d.pass  = 1'b0;
                    r_d.err   = 1'b0;
                    r_d.idx   = '0;
                end
            end
            ST_TYPE: begin
                rd_valid_o = 1'b1;
                rd_addr_o  = ADDR_TYPE;
                r_d.state  = ST_CFG;
            end
            ST_CFG: begin
                rd_valid_o = 1'b1;
                rd_addr_o  = ADDR_CFG;
                r_d.mtype  = rd_data_i;
                r_d.state  = ST_SEL;
            end
            ST_SEL: begin
                if (r_q.mtype == TYPE_SDR || r_q.mtype == TYPE_DDR ||
                    r_q.mtype == TYPE_DDR2) begin
                    r_d.is_crc = 1'b0;
                    r_d.last   = SUM_LAST;
                    r_d.stored = SUM_STORED;
                    r_d.state  = ST_STREAM;
                end else if (r_q.mtype == TYPE_DDR3) begin
                    r_d.is_crc = 1'b1;
                    r_d.last   = rd_data_i[7] ? CRC_LAST_SHRT : CRC_LAST_LONG;
                    r_d.stored = CRC_STORED_LO;
                    r_d.state  = ST_STREAM;
                end else begin
                    r_d.is_crc = 1'b0;
                    r_d.done   = 1'b1;
                    r_d.err    = 1'b1;
                    r_d.pass   = 1'b0;
                    r_d.state  = ST_IDLE;
                end
            end
            ST_STREAM: begin
                rd_valid_o = 1'b1;
                rd_addr_o  = r_q.idx;
                r_d.feed   = 1'b1;
                r_d.idx    = r_q.idx + 1'b1;
                if (r_q.idx == r_q.last) r_d.state = ST_CHK1;
            end
            ST_CHK1: begin
                rd_valid_o = 1'b1;
                rd_addr_o  = r_q.stored;
                r_d.state  = ST_CHK2;
            end
            ST_CHK2: begin
                if (r_q.is_crc) begin
                    rd_valid_o = 1'b1;
                    rd_addr_o  = CRC_STORED_HI;
                    r_d.lo     = rd_data_i;
                    r_d.state  = ST_CHK3;
                end else begin
                    r_d.pass  = (rd_data_i == sum_val);
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            ST_CHK3: begin
                r_d.pass  = ({rd_data_i, r_q.lo} == crc_val);
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;
    assign pass_o = r_q.pass;
    assign err_o  = r_q.err;
    assign calc_o = r_q.is_crc ? crc_val : {{(CW-DW){1'b0}}, sum_val};

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rd_addr_o <= CRC_STORED_HI)); // R9
    AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && start_i) |=> (rd_valid_o && rd_addr_o == ADDR_TYPE)); // R9
    AST_ERR_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !pass_o); // R6
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_STREAM && start_i) |=> (r_q.state == ST_STREAM || r_q.state == ST_CHK1)); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (done_o || ($stable(pass_o) && $stable(err_o)))); // R8
endmodule

// File: tb/desc_integrity_chk_bench.sv
module desc_integrity_chk_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_valid_o;
    logic [7:0]  rd_addr_o;
    logic [7:0]  rd_data_i;
    logic        done_o, pass_o, err_o;
    logic [15:0] calc_o;

    logic [7:0]  mem [256];
    int          n_tests = 0;
    int          n_fail  = 0;

    int          r_reads, r_dones, r_first0, r_first1;
    logic        r_pass, r_err;
    logic [15:0] r_calc;

    always #2 clk = ~clk;

    always_ff @(posedge clk) if (rd_valid_o) rd_data_i <= mem[rd_addr_o];

    desc_integrity_chk u_desc_integrity_chk (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .done_o(done_o), .pass_o(pass_o), .err_o(err_o), .calc_o(calc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int last);
        logic [15:0] c = 16'h0;
        for (int a = 0; a <= last; a++)
            for (int b = 7; b >= 0; b--) begin
                logic f = c[15] ^ mem[a][b];
                c = {c[14:0], 1'b0};
                if (f) c = c ^ 16'h1021;
            end
        return c;
    endfunction

    function automatic logic [7:0] ref_sum();
        logic [7:0] s = 8'h0;
        for (int a = 0; a <= 62; a++) s = s + mem[a];
        return s;
    endfunction

    task automatic fill(input int seed, input logic [7:0] mtype, input logic flag);
        for (int a = 0; a < 256; a++) mem[a] = 8'((a * 37 + seed * 11 + (a >> 3)) ^ seed);
        mem[2] = mtype;
        mem[0] = {flag, mem[0][6:0]};
    endtask

    // runs one check; extra start pulse at cycle busy_at when >= 0
    task automatic run(input int busy_at);
        int cyc = 0;
        r_reads = 0; r_dones = 0; r_first0 = -1; r_first1 = -1;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (cyc < 2000) begin
            start_i = (cyc == busy_at);
            if (rd_valid_o) begin
                if (r_reads == 0) r_first0 = rd_addr_o;
                if (r_reads == 1) r_first1 = rd_addr_o;
                r_reads++;
            end
            if (done_o) begin
                r_dones++;
                r_pass = pass_o; r_err = err_o; r_calc = calc_o;
            end
            if (r_dones > 0 && !done_o && cyc > busy_at + 2) break;
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0;
        if (cyc >= 2000) chk("watchdog", 0, 1);
    endtask

    task automatic t_reset();
        chk("R1 done", done_o, 0);
        chk("R1 pass", pass_o, 0);
        chk("R1 err", err_o, 0);
        chk("R1 rd_valid", rd_valid_o, 0);
    endtask

    task automatic t_sum_pass(input logic [7:0] ty, input int seed);
        fill(seed, ty, 1'b0);
        mem[63] = ref_sum();
        run(-1);
        chk("R2 pass", r_pass, 1);
        chk("R2 calc", r_calc, {8'h0, mem[63]});
        chk("R9 reads sum", r_reads, 66);
        chk("R9 first addr", r_first0, 2);
        chk("R9 second addr", r_first1, 0);
        chk("R8 one done", r_dones, 1);
        chk("R8 pass held", pass_o, 1);
    endtask

    task automatic t_sum_wrap_fail();
        for (int a = 0; a < 64; a++) mem[a] = 8'hFF;
        mem[2] = 8'd7;
        mem[63] = 8'hC9 + 8'd1;     // true sum is 0xC9, stored value off by one
        run(-1);
        chk("R3 fail", r_pass, 0);
        chk("R3 calc", r_calc, 16'h00C9);
        chk("R3 err clear", r_err, 0);
    endtask

    task automatic t_crc_full();
        logic [15:0] c;
        fill(5, 8'd11, 1'b0);
        c = ref_crc(125);
        mem[126] = c[7:0]; mem[127] = c[15:8];
        run(-1);
        chk("R4 pass", r_pass, 1);
        chk("R4 calc", r_calc, c);
        chk("R9 reads crc long", r_reads, 130);
        mem[120] = mem[120] ^ 8'h10;
        run(-1);
        chk("R4 byte 120 covered", r_pass, 0);
    endtask

    task automatic t_crc_short();
        logic [15:0] c;
        fill(9, 8'd11, 1'b1);
        c = ref_crc(116);
        mem[126] = c[7:0]; mem[127] = c[15:8];
        mem[120] = mem[120] ^ 8'h5A;
        run(-1);
        chk("R5 pass despite 120", r_pass, 1);
        chk("R5 calc", r_calc, c);
        chk("R9 reads crc short", r_reads, 121);
        mem[127] = mem[127] ^ 8'h01;
        run(-1);
        chk("R4 hi byte order", r_pass, 0);
    endtask

    task automatic t_unknown();
        fill(3, 8'd9, 1'b0);
        run(-1);
        chk("R6 err", r_err, 1);
        chk("R6 pass", r_pass, 0);
        chk("R6 reads", r_reads, 2);
        chk("R8 err held", err_o, 1);
        fill(4, 8'd4, 1'b0);
        mem[63] = ref_sum();
        run(-1);
        chk("R6 err cleared", r_err, 0);
        chk("R6 next pass", r_pass, 1);
    endtask

    task automatic t_busy();
        fill(6, 8'd8, 1'b0);
        mem[63] = ref_sum();
        run(20);
        chk("R7 one done", r_dones, 1);
        chk("R7 reads", r_reads, 66);
        chk("R7 pass", r_pass, 1);
        chk("R7 idle after", rd_valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sum_pass(8'd4, 1);
        t_sum_pass(8'd7, 2);
        t_sum_pass(8'd8, 7);
        t_sum_wrap_fail();
        t_crc_full();
        t_crc_short();
        t_unknown();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule